// File: doc/BRIEF.md
# Board Interrupt-Level Encoder with Control Registers

This block sits on a board controller and gathers thirteen level-sensitive interrupt lines from peripherals. Each clock it records the line levels in a 16-bit monitor register. It ANDs that register with a software-owned 16-bit enable mask. From the enabled, asserted sources it picks the one with the best (numerically smallest) priority level. It then drives that level to the processor as a 4-bit code.

The code is the winning level XOR 15. The most urgent source therefore drives 15, and an idle controller drives 0. Each source has a fixed bit in the monitor and mask registers, and these bits do not follow priority order.

The block also decodes a 64-byte register window. Every access is a 16-bit halfword through a simple valid/write strobe. The window holds the mask, a general output-port latch, a constant identification value and a power-off control. A write to the power-off control with bit 0 set produces a one-cycle shutdown request.

Top module: `brd_irq_ctrl`

## Requirements
- R1: After reset, the level output is 0 and the shutdown request is low. The mask register and the output-port register both read 0.
- R2: `irq_in[i]` is the source whose priority level is i, for i = 0..12. Its monitor and mask bit is, by level from 0 to 12: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. The monitor register follows the input levels, and a source is pending only when its input is high and its mask bit is 1.
- R3: The output is the smallest pending level XOR 15. It is 0 when nothing is pending, and 15 when the level-0 source is pending.
- R4: The output is registered. It takes its new value at the first rising clock edge after an input change, and holds its old value before that edge.
- R5: The mask register at byte offset 0x00 is read/write over all 16 bits. A mask write applies to the level output at the same edge at which the mask is stored.
- R6: The output-port register at offset 0x36 reads back the last value written to it.
- R7: The identification register at offset 0x32 always reads 0x0010. Writes to it change no register.
- R8: The power-off control at offset 0x30 reads 0. A write with bit 0 set makes `shutdown_req` high for exactly the cycle after the write edge. A write with bit 0 clear gives no pulse.
- R9: A read of any other even offset, or of any odd offset, returns 0. A write to an odd offset changes no register.
- R10: Mask bits 1, 2 and 3 belong to no source. They are stored and read back, but have no effect on the level output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 13 | Peripheral interrupt levels, index = priority level |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of a read strobe |
| irl_out | output | 4 | Encoded interrupt level (winning level XOR 15) |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The assertions check, on every cycle, that the level code agrees with the registered pending set. The code is zero exactly when nothing is pending, and otherwise it names a source that is really pending. They also check that the mask and output-port registers change only on a write to their own offset, and that every shutdown pulse follows a qualifying power-off write.

Only the bench scenarios can show the rest: that the smallest level wins under the scrambled bit map, and the cycle in which the output moves after an input or mask change. The same holds for the read values of the constant, power-off and unmapped offsets, and for odd-offset writes being dropped.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
  localparam int NUM_SRC = 13;
  localparam int REG_W   = 16;
  localparam int LVL_W   = 4;
  localparam int ADDR_W  = 6;
  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  // register bit owned by the source of a given priority level
  function automatic int unsigned src_bit(input int unsigned lvl);
    case (lvl)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      12: return 15;
      default: return 1;
    endcase
  endfunction

  // priority level owned by a register bit; unowned bits rank as idle
  function automatic logic [LVL_W-1:0] bit_level(input int unsigned b);
    for (int s = 0; s < NUM_SRC; s++)
      if (src_bit(s) == b) return LVL_W'(s);
    return IDLE_LVL;
  endfunction

  // smallest level among pending register bits
  function automatic logic [LVL_W-1:0] pick_level(input logic [REG_W-1:0] pend);
    logic [LVL_W-1:0] best;
    best = IDLE_LVL;
    for (int b = 0; b < REG_W; b++)
      if (pend[b] && bit_level(b) < best) best = bit_level(b);
    return best;
  endfunction

  function automatic logic [LVL_W-1:0] level_code(input logic [LVL_W-1:0] lvl);
    return lvl ^ IDLE_LVL;
  endfunction
endpackage

// File: rtl/brd_irq_prio.sv
module brd_irq_prio
  import brd_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [REG_W-1:0]   mask_nxt,
  input  logic [REG_W-1:0]   mask_q,
  output logic [LVL_W-1:0]   irl_out
);
  logic [REG_W-1:0] mon_d, mon_q;
  logic [REG_W-1:0] pend_d, pend_q;
  logic [LVL_W-1:0] code_q;

  // place each line at its register bit
  always_comb begin
    mon_d = '0;
    for (int i = 0; i < NUM_SRC; i++) mon_d[src_bit(i)] = irq_in[i];
  end

  assign pend_d = mon_d & mask_nxt;
  assign pend_q = mon_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_q  <= '0;
      code_q <= '0;
    end else begin
      mon_q  <= mon_d;
      code_q <= level_code(pick_level(pend_d));
    end
  end

  assign irl_out = code_q;

  // R3
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_out == '0) == (pend_q == '0));
  // R3
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_out != '0) |-> pend_q[src_bit(int'(irl_out ^ IDLE_LVL))]);
  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_out != '0) |-> (int'(irl_out ^ IDLE_LVL) < NUM_SRC));
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
  import brd_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OFS_MASK = 6'h00,
  parameter logic [ADDR_W-1:0] OFS_PWR  = 6'h30,
  parameter logic [ADDR_W-1:0] OFS_ID   = 6'h32,
  parameter logic [ADDR_W-1:0] OFS_PORT = 6'h36,
  parameter logic [REG_W-1:0]  ID_VAL   = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  mask_q,
  output logic [REG_W-1:0]  mask_nxt,
  output logic              shutdown_req
);
  logic [REG_W-1:0] port_q;
  logic             shut_q;
  logic             acc_ok, wr_ok, rd_ok;
  logic             wr_mask, wr_port, wr_pwr_go;

  assign acc_ok    = bus_valid && !bus_addr[0];
  assign wr_ok     = acc_ok && bus_write;
  assign rd_ok     = acc_ok && !bus_write;
  assign wr_mask   = wr_ok && (bus_addr == OFS_MASK);
  assign wr_port   = wr_ok && (bus_addr == OFS_PORT);
  assign wr_pwr_go = wr_ok && (bus_addr == OFS_PWR) && bus_wdata[0];

  assign mask_nxt = wr_mask ? bus_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      port_q <= '0;
      shut_q <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      if (wr_port) port_q <= bus_wdata;
      shut_q <= wr_pwr_go;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (bus_addr)
        OFS_MASK: bus_rdata = mask_q;
        OFS_PORT: bus_rdata = port_q;
        OFS_ID:   bus_rdata = ID_VAL;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign shutdown_req = shut_q;

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  // R6
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_port |=> $stable(port_q));
  // R8
  shut_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(bus_valid && bus_write && bus_wdata[0]));
endmodule

// File: rtl/brd_irq_ctrl.sv
module brd_irq_ctrl
  import brd_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [LVL_W-1:0]   irl_out,
  output logic               shutdown_req
);
  logic [REG_W-1:0] mask_q, mask_nxt;

  brd_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mask_q(mask_q), .mask_nxt(mask_nxt), .shutdown_req(shutdown_req)
  );

  brd_irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_nxt(mask_nxt), .mask_q(mask_q), .irl_out(irl_out)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (irl_out == '0 && !shutdown_req));
endmodule

// File: tb/brd_irq_ctrl_test.sv
module brd_irq_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] irq_in = '0;
  logic        bus_valid = 0, bus_write = 0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_out;
  logic        shutdown_req;

  int checks = 0, fails = 0;
  bit done = 0;

  brd_irq_ctrl uut (.*);

  always #5 clk = ~clk;

  localparam int BMAP [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  function automatic logic [3:0] model(input logic [12:0] irq, input logic [15:0] msk);
    for (int l = 0; l < 13; l++)
      if (irq[l] && msk[BMAP[l]]) return 4'(15 - l);
    return 4'd0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic set_irq(input logic [12:0] v);
    @(negedge clk); irq_in = v;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, mask_m;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 irl", 16'(irl_out), 0);
    chk("R1 shutdown", 16'(shutdown_req), 0);
    @(negedge clk) rst_n = 1;
    rd(6'h00, v); chk("R1 mask", v, 0);
    rd(6'h36, v); chk("R1 port", v, 0);

    // R5 mask read/write
    wr(6'h00, 16'hFFFF); rd(6'h00, v); chk("R5 mask rb", v, 16'hFFFF);

    // R3 priority cases
    set_irq(13'h0001); chk("R3 lvl0", 16'(irl_out), 15);
    set_irq(13'h1FFF); chk("R3 all", 16'(irl_out), 15);
    set_irq(13'h1000); chk("R3 lvl12", 16'(irl_out), 3);
    set_irq(13'h0000); chk("R3 none", 16'(irl_out), 0);
    set_irq(13'h0300); chk("R2 lvl8+9", 16'(irl_out), 7);

    // R4 timing: old value before the edge, new after
    @(negedge clk); irq_in = 13'h0020;
    #2 chk("R4 hold", 16'(irl_out), 7);
    @(posedge clk); #1 chk("R4 update", 16'(irl_out), 10);

    // R2 masking of level 0 (bit 11)
    wr(6'h00, 16'hF7FF); set_irq(13'h1FFF); chk("R2 mask lvl0", 16'(irl_out), 14);
    // R5 mask write applies at its own edge
    wr(6'h00, 16'h0000); chk("R5 immediate", 16'(irl_out), 0);
    // R10 unused mask bits
    wr(6'h00, 16'h000E); chk("R10 unused bits", 16'(irl_out), 0);
    rd(6'h00, v); chk("R10 stored", v, 16'h000E);

    // R6 output port
    wr(6'h36, 16'hA5C3); rd(6'h36, v); chk("R6 port", v, 16'hA5C3);
    // R7 identification
    rd(6'h32, v); chk("R7 id", v, 16'h0010);
    wr(6'h32, 16'hFFFF); rd(6'h32, v); chk("R7 id after wr", v, 16'h0010);
    rd(6'h36, v); chk("R7 port kept", v, 16'hA5C3);
    rd(6'h00, v); chk("R7 mask kept", v, 16'h000E);

    // R8 power-off
    rd(6'h30, v); chk("R8 read", v, 0);
    wr(6'h30, 16'h0001); chk("R8 pulse", 16'(shutdown_req), 1);
    @(posedge clk); #1 chk("R8 one cycle", 16'(shutdown_req), 0);
    wr(6'h30, 16'h0002); chk("R8 no pulse", 16'(shutdown_req), 0);

    // R9 unmapped and odd offsets
    rd(6'h02, v); chk("R9 0x02", v, 0);
    rd(6'h3E, v); chk("R9 0x3E", v, 0);
    rd(6'h01, v); chk("R9 odd rd", v, 0);
    wr(6'h01, 16'h1234); rd(6'h00, v); chk("R9 odd wr mask", v, 16'h000E);
    wr(6'h37, 16'h1234); rd(6'h36, v); chk("R9 odd wr port", v, 16'hA5C3);

    // R2 R3 R5 random mix
    mask_m = 16'h000E;
    for (int k = 0; k < 400; k++) begin
      logic [12:0] r;
      r = 13'($urandom);
      @(negedge clk);
      irq_in = r;
      if ($urandom_range(0, 3) == 0) begin
        mask_m = 16'($urandom);
        bus_valid = 1; bus_write = 1; bus_addr = 6'h00; bus_wdata = mask_m;
      end
      @(posedge clk); #1;
      bus_valid = 0; bus_write = 0;
      chk("R3 random", 16'(irl_out), 16'(model(r, mask_m)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule